// File: doc/BRIEF.md
# Register Byte-Swap Execution Unit

This unit carries out an already-decoded byte-swap operation on one entry of a sixteen-entry, 64-bit general register file. Each request brings the low bits of the opcode byte, the four extension-prefix bits (W, R, X, B), the operand-size override flag and the current execution mode. The unit uses these to pick the target register and the operand width. It reads the register, forms the result and writes it back on the clock edge that accepts the request. A one-cycle `done` pulse follows.

The operand width sets the result. The 64-bit form reverses all eight bytes. The 32-bit form reverses the low four bytes. The 16-bit form does not swap anything: it clears the low sixteen bits and keeps the rest. Only the B extension bit widens the register index. The R and X bits are accepted and have no effect. A load port and a combinational read port give the surrounding pipeline, or a bench, direct access to the register file.

Top module: `bswap_exec`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared to zero and `done` is cleared to 0.
- R2: The 32-bit form reverses the low four bytes: byte 0 goes to byte 3, byte 1 goes to byte 2, and the reverse. For example, 0x11223344 becomes 0x44332211.
- R3: The low three bits of `opcode` select registers 0 to 7 (opcode 0xC8 + n selects register n). Bits 7:3 of `opcode` are ignored.
- R4: In 64-bit mode, `rex_b` set adds 8 to the register index. With opcode 0xC8 this targets register 8, and register 0 is left unchanged.
- R5: `rex_r` and `rex_x` never change the selected register or the result. Every register other than the target keeps its value.
- R6: The 16-bit form writes zero to bits 15:0 of the target and keeps bits 63:16. For example, 0x98765432 becomes 0x98760000. This holds for all sixteen registers.
- R7: `mode` encoding: 2'b00 = 16-bit mode, 2'b01 = 32-bit mode, 2'b1x = 64-bit mode. The 16-bit form is used when exactly one of two conditions holds: the mode is 16-bit, or `opsize_ovr` is set. Otherwise the 32-bit form is used.
- R8: In 64-bit mode, the 32-bit form clears bits 63:32 of the target. In 16-bit and 32-bit modes, it keeps bits 63:32.
- R9: In 64-bit mode, `rex_w` set selects the 64-bit form, which reverses all eight bytes. This takes priority over `opsize_ovr`.
- R10: Outside 64-bit mode, `rex_w` and `rex_b` have no effect.
- R11: A request sampled at a clock edge updates the register at that same edge. `done` is high for exactly the following cycle. Without a request, no register changes except through the load port.
- R12: `ld_en` writes `ld_data` into register `ld_idx` at the next edge. If a request targets the same register in the same cycle, the byte-swap write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Byte-swap request this cycle |
| opcode | input | 8 | Opcode byte; bits 2:0 name the register |
| rex_w | input | 1 | Extension W bit (64-bit operand) |
| rex_r | input | 1 | Extension R bit (ignored) |
| rex_x | input | 1 | Extension X bit (ignored) |
| rex_b | input | 1 | Extension B bit (index bit 3) |
| opsize_ovr | input | 1 | Operand-size override prefix present |
| mode | input | 2 | Execution mode: 00 = 16-bit, 01 = 32-bit, 1x = 64-bit |
| ld_en | input | 1 | Register load enable |
| ld_idx | input | 4 | Register load index |
| ld_data | input | 64 | Register load value |
| rd_idx | input | 4 | Read-port index |
| rd_data | output | 64 | Read-port value (combinational) |
| done | output | 1 | Write-back completed last edge |

## Verification
The bench sweeps the full cross of the four mode codes, the override flag and the W, B, R and X bits over all eight opcode registers. Before each operation it loads fresh, distinct patterns into all sixteen registers, then reads all sixteen back afterwards. This separates the three result forms and the legacy versus 64-bit treatment of the upper half. It also shows whether B, R or X moved the write to another register. Directed cases use the known values 0x11223344 and 0x98765432, and the register 0 versus register 8 pair under each extension bit. A load that collides with a request on the same register checks the write priority.

// File: rtl/bswap_pkg.sv
`timescale 1ns/1ps
// Shared types for the byte-swap execution unit.
// Assumes a 64-bit datapath; the kinds name the three result forms.
package bswap_pkg;
    typedef enum logic [1:0] {
        SW_ZERO16 = 2'd0,
        SW_REV32  = 2'd1,
        SW_REV64  = 2'd2
    } sw_kind_e;

    localparam logic [1:0] MODE_16 = 2'b00;
endpackage

// File: rtl/bswap_decode.sv
`timescale 1ns/1ps
// Target/width decode for the byte-swap operation.
// Turns opcode low bits, extension bits, override and mode into a register
// index and a result kind. Assumes mode[1] marks 64-bit mode.
module bswap_decode
    import bswap_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-2:0] opc_lo,
    input  logic             ext_w,
    input  logic             ext_b,
    input  logic             ovr,
    input  logic [1:0]       mode,
    output logic [IDX_W-1:0] idx,
    output sw_kind_e         kind,
    output logic             clr_hi
);
    logic long_mode;
    logic narrow;

    // Decide index extension, operand width and upper-half treatment.
    always_comb begin
        long_mode = mode[1];
        narrow    = (mode == MODE_16) ^ ovr;
        idx       = {long_mode & ext_b, opc_lo};
        clr_hi    = long_mode;
        if (long_mode && ext_w)
            kind = SW_REV64;
        else if (narrow)
            kind = SW_ZERO16;
        else
            kind = SW_REV32;
    end
endmodule

// File: rtl/bswap_swap.sv
`timescale 1ns/1ps
// Result former: full byte reversal, low-half byte reversal, or low-16 clear.
// Assumes DATA_W is a multiple of 16 bits.
module bswap_swap
    import bswap_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] src,
    input  sw_kind_e          kind,
    input  logic              clr_hi,
    output logic [DATA_W-1:0] result
);
    localparam int NBYTES = DATA_W / 8;
    localparam int HALF_W = DATA_W / 2;
    localparam int HBYTES = NBYTES / 2;
    localparam int ZERO_W = 16;

    logic [DATA_W-1:0] rev_full;
    logic [HALF_W-1:0] rev_half;

    // Wire-only byte reversals for both widths.
    for (genvar g = 0; g < NBYTES; g++) begin : g_full
        assign rev_full[g*8 +: 8] = src[(NBYTES-1-g)*8 +: 8];
    end
    for (genvar h = 0; h < HBYTES; h++) begin : g_half
        assign rev_half[h*8 +: 8] = src[(HBYTES-1-h)*8 +: 8];
    end

    // Select the result form.
    always_comb begin
        unique case (kind)
            SW_REV64:  result = rev_full;
            SW_ZERO16: result = {src[DATA_W-1:ZERO_W], {ZERO_W{1'b0}}};
            default:   result = {clr_hi ? {HALF_W{1'b0}} : src[DATA_W-1:HALF_W], rev_half};
        endcase
    end
endmodule

// File: rtl/bswap_regfile.sv
`timescale 1ns/1ps
// General register file: one execution write port, one load port,
// two combinational read ports. Execution write has priority on a collision.
module bswap_regfile #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] regs [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Per-entry storage with clear, execution write, then load.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                regs[g] <= wr_data;
            else if (ld_en && ld_idx == IDX_W'(g))
                regs[g] <= ld_data;
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];
endmodule

// File: rtl/bswap_exec.sv
`timescale 1ns/1ps
// Byte-swap execution unit: decode target and width, read the register,
// form the result and write it back at the accepting edge; pulse done after.
// Assumes the request is already identified as a byte-swap operation.
module bswap_exec
    import bswap_pkg::*;
#(
    parameter int NREGS  = 16,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        opcode,
    input  logic              rex_w,
    input  logic              rex_r,
    input  logic              rex_x,
    input  logic              rex_b,
    input  logic              opsize_ovr,
    input  logic [1:0]        mode,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    logic [IDX_W-1:0]  tgt_idx;
    sw_kind_e          kind;
    logic              clr_hi;
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] res;
    logic              unused_bits;

    // R and X extension bits and opcode high bits carry no meaning here.
    assign unused_bits = ^{rex_r, rex_x, opcode[7:IDX_W-1]};

    bswap_decode #(.IDX_W(IDX_W)) u_dec (
        .opc_lo (opcode[IDX_W-2:0]),
        .ext_w  (rex_w),
        .ext_b  (rex_b),
        .ovr    (opsize_ovr),
        .mode   (mode),
        .idx    (tgt_idx),
        .kind   (kind),
        .clr_hi (clr_hi)
    );

    bswap_regfile #(.DEPTH(NREGS), .DATA_W(DATA_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (req_valid),
        .wr_idx  (tgt_idx),
        .wr_data (res),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .ra_idx  (tgt_idx),
        .ra_data (src),
        .rb_idx  (rd_idx),
        .rb_data (rd_data)
    );

    bswap_swap #(.DATA_W(DATA_W)) u_swap (
        .src    (src),
        .kind   (kind),
        .clr_hi (clr_hi),
        .result (res)
    );

    // Completion pulse one cycle after an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= req_valid;
    end

    AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done); // R11
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req_valid)); // R11
    AST_LEGACY_LOW_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode[1]) |-> !tgt_idx[IDX_W-1]); // R10
    AST_ZERO16_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == SW_ZERO16) |->
            (res[15:0] == 16'h0 && res[DATA_W-1:16] == src[DATA_W-1:16])); // R6
    AST_REV64_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == SW_REV64) |->
            (res[7:0] == src[DATA_W-1:DATA_W-8] && res[DATA_W-1:DATA_W-8] == src[7:0])); // R9
    AST_LONG_CLEARS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode[1] && kind == SW_REV32) |-> res[DATA_W-1:DATA_W/2] == '0); // R8
endmodule

// File: tb/tb_bswap_exec.sv
`timescale 1ns/1ps
// Self-checking sweep bench for the byte-swap execution unit.
module tb_bswap_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  opcode = 8'hC8;
    logic        rex_w = 0, rex_r = 0, rex_x = 0, rex_b = 0, opsize_ovr = 0;
    logic [1:0]  mode = 2'b01;
    logic        ld_en = 0;
    logic [3:0]  ld_idx = 0;
    logic [63:0] ld_data = 0;
    logic [3:0]  rd_idx = 0;
    logic [63:0] rd_data;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] mdl [16];

    always #4 clk = ~clk;

    bswap_exec dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
        .rex_w(rex_w), .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b),
        .opsize_ovr(opsize_ovr), .mode(mode), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data), .done(done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [63:0] pat(input int i, input int n);
        logic [31:0] hi, lo;
        hi = 32'(n) * 32'h9E3779B9 + 32'(i) * 32'h01010101 ^ 32'hA5C3_0F1E;
        lo = 32'(i) * 32'h11223344 + 32'(n) * 32'h00C0FFEE + 32'h0BAD_F00D;
        return {hi, lo};
    endfunction

    // Expected result from the requirement text (R2, R6..R10).
    function automatic logic [63:0] model(input logic [1:0] md, input logic ov,
                                          input logic w, input logic [63:0] s);
        logic [31:0] sw;
        logic [63:0] r;
        sw = {s[7:0], s[15:8], s[23:16], s[31:24]};
        if (md[1] && w)
            for (int k = 0; k < 8; k++) r[k*8 +: 8] = s[(7-k)*8 +: 8];
        else if ((md == 2'b00) ^ ov)
            r = {s[63:16], 16'h0};
        else
            r = {md[1] ? 32'h0 : s[63:32], sw};
        return r;
    endfunction

    task automatic load(input int i, input logic [63:0] v);
        @(negedge clk);
        ld_en = 1; ld_idx = 4'(i); ld_data = v; mdl[i] = v;
        @(negedge clk);
        ld_en = 0;
    endtask

    task automatic load_all(input int n);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            ld_en = 1; ld_idx = 4'(i); ld_data = pat(i, n); mdl[i] = pat(i, n);
        end
        @(negedge clk);
        ld_en = 0;
    endtask

    task automatic read_chk(input int i, input string tag);
        rd_idx = 4'(i);
        #1;
        chk($sformatf("%s reg%0d", tag, i), rd_data, mdl[i]);
    endtask

    task automatic run_op(input logic [1:0] md, input logic ov, input logic w,
                          input logic b, input logic x, input logic r,
                          input int rg, input string tag);
        int t;
        logic [63:0] e;
        t = (md[1] && b) ? rg + 8 : rg;
        e = model(md, ov, w, mdl[t]);
        @(negedge clk);
        req_valid = 1; opcode = 8'hC8 + 8'(rg); mode = md; opsize_ovr = ov;
        rex_w = w; rex_b = b; rex_x = x; rex_r = r;
        @(negedge clk);
        req_valid = 0;
        mdl[t] = e;
        chk("R11 done after request", {63'h0, done}, 64'h1);
        for (int i = 0; i < 16; i++)
            read_chk(i, (i == t) ? tag : "R5 R11 non-target unchanged");
        @(negedge clk);
        chk("R11 done single cycle", {63'h0, done}, 64'h0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8ns * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done in reset", {63'h0, done}, 64'h0);
        rst_n = 1;
        for (int i = 0; i < 16; i++) begin
            mdl[i] = 64'h0;
            read_chk(i, "R1 reset value");
        end

        // R2: basic 32-bit reversal
        load(0, 64'h0000_0000_1122_3344);
        run_op(2'b01, 0, 0, 0, 0, 0, 0, "R2 rev32");
        chk("R2 known value", mdl[0], 64'h0000_0000_4433_2211);

        // R4/R5: register 0 vs register 8 under each extension bit
        load(0, 64'h5566_7788); load(8, 64'h5566_7788);
        run_op(2'b10, 0, 0, 0, 1, 0, 0, "R5 rex_x keeps reg0 target");
        chk("R5 reg8 untouched by rex_x", mdl[8], 64'h5566_7788);
        load(0, 64'h5566_7788);
        run_op(2'b10, 0, 0, 0, 0, 1, 0, "R5 rex_r keeps reg0 target");
        load(0, 64'h5566_7788);
        run_op(2'b10, 0, 0, 1, 0, 0, 0, "R4 rex_b targets reg8");
        chk("R4 reg8 swapped", mdl[8], 64'h8877_6655);

        // R6/R7: 16-bit form known value, each mode entry
        load(3, 64'h9876_5432);
        run_op(2'b01, 1, 0, 0, 0, 0, 3, "R6 R7 zero16 via override");
        chk("R6 known value", mdl[3], 64'h9876_0000);
        load(5, 64'hFFFF_FFFF_9876_5432);
        run_op(2'b00, 0, 0, 0, 0, 0, 5, "R6 R7 zero16 default in 16-bit mode");
        load(5, 64'hFFFF_FFFF_9876_5432);
        run_op(2'b00, 1, 0, 0, 0, 0, 5, "R7 override gives rev32 in 16-bit mode");

        // R6: zero16 on all sixteen registers
        for (int i = 0; i < 16; i++) begin
            load(i, 64'hFFFF_FFFF_9876_5432);
            run_op(2'b10, 1, 0, i >= 8, 0, 0, i % 8, "R6 zero16 every register");
        end

        // R12: collision of load and request on one register
        load(2, 64'h0102_0304_0506_0708);
        @(negedge clk);
        req_valid = 1; opcode = 8'hCA; mode = 2'b10; rex_w = 1; rex_b = 0;
        rex_x = 0; rex_r = 0; opsize_ovr = 0;
        ld_en = 1; ld_idx = 4'd2; ld_data = 64'hDEAD_BEEF_DEAD_BEEF;
        @(negedge clk);
        req_valid = 0; ld_en = 0;
        mdl[2] = 64'h0807_0605_0403_0201;
        read_chk(2, "R12 swap wins collision");
        load(2, 64'h0123_4567_89AB_CDEF);
        read_chk(2, "R12 load writes value");

        // Full sweep: R3 R4 R5 R7 R8 R9 R10
        n = 0;
        for (int md = 0; md < 4; md++)
            for (int ov = 0; ov < 2; ov++)
                for (int w = 0; w < 2; w++)
                    for (int b = 0; b < 2; b++)
                        for (int xr = 0; xr < 4; xr++)
                            for (int rg = 0; rg < 8; rg++) begin
                                string tg;
                                n++;
                                load_all(n);
                                if (md >= 2 && w == 1)      tg = "R9 R3 R4 rev64";
                                else if ((md == 0) ^ (ov == 1)) tg = "R6 R7 R10 zero16";
                                else if (md >= 2)           tg = "R8 R2 R3 R4 rev32 long";
                                else                        tg = "R8 R2 R10 rev32 legacy";
                                run_op(2'(md), 1'(ov), 1'(w), 1'(b), xr[0], xr[1], rg, tg);
                            end
        finish_up();
    end
endmodule